// File: doc/BRIEF.md
# Host Channel Interrupt Aggregator

This block folds the interrupt status of a set of host channels into one interrupt request line through three levels of status and mask. Each channel keeps a status register whose bits are set by event pulses from the channel's transfer logic and cleared by software writing ones. Each channel also keeps a mask register. A channel that has any unmasked pending bit lights its bit in a summary register. The summary is gated by a summary mask, and the result drives the host-channel bit of a global status register. The global status is gated by a global mask and by a global enable bit to form the request line.

The summary bit and the host-channel global bit are not stored. They are recomputed from the lower levels every cycle, so clearing the last pending channel bit removes the request with no extra software step. The global status also carries a port-pending bit, which follows an input level from the port logic, and general bits that are set by event pulses and cleared by writing ones. Software reaches every register through a 32-bit word-addressed write port with a combinational read port. Disabling an enabled channel through its control word marks that channel as halted.

Top module: `usb_hirq_agg`

## Requirements
- R1: After reset the line irq_o is low, and every channel status, channel mask, channel enable, summary mask, global mask, global enable and general global status bit reads as zero.
- R2: A pulse on a channel event input sets the matching bits of that channel's status register (byte offset 0x08 in the channel window). A write to that register clears exactly the bits written as one and leaves every other bit unchanged.
- R3: Channel status and channel mask registers are 14 bits wide. Bits 14 to 31 read as zero even after a write of all ones.
- R4: Channel c occupies the 32-byte window that starts at byte 0x100 + 0x20*c, with control at +0x00, status at +0x08 and mask at +0x0C. Bit c of the summary register (read-only, byte 0x010) is one exactly when that channel's status AND mask is nonzero.
- R5: Bit 25 of the global status register (byte 0x004) is one exactly when the summary AND the summary mask (byte 0x014) is nonzero.
- R6: Global status bits 25 and 24 are read-only. Writes do not change them. Bit 24 follows the port_pend input.
- R7: Every other global status bit is set by a pulse on the matching sys_evt bit and cleared by writing one to it.
- R8: irq_o is high in the cycle after one in which (global status AND global mask at byte 0x008) is nonzero and bit 0 of the configuration register (byte 0x000) is set. In any other case irq_o is low in that following cycle.
- R9: A write of bit 0 = 0 to the control word of an enabled channel clears its enable and sets bit 1 (halted) of its status. The same write to a disabled channel leaves the status unchanged.
- R10: irq_o is driven from a flop and changes only when the computed request level differs from its present value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| chan_evt | input | NCH*14 | Status-set pulses, 14 bits per channel, channel 0 in the lowest bits |
| port_pend | input | 1 | Port-pending level shown in global status bit 24 |
| sys_evt | input | 32 | Set pulses for the general global status bits |
| irq_o | output | 1 | Interrupt request level |

## Verification
The bench checks that an event on a masked-off channel leaves the summary clear. A design that latched unmasked status would raise the request too early. It clears a non-pending bit and then the pending one, so a clear of the wrong bit shows up as stale status. It also checks that the last clear drops bit 25 and the request, which would not happen if the summary were stored rather than derived. It removes a channel from the summary mask, writes all ones over the read-only global bits, and disables channels in both the enabled and the disabled state. It measures the one-cycle request latency in both directions, which catches a request path that is combinational or takes two flops.

// File: rtl/hirq_pkg.sv
package hirq_pkg;
   localparam int STW       = 14;
   localparam int HALT_BIT  = 1;
   localparam int HCH_BIT   = 25;
   localparam int PORT_BIT  = 24;
   localparam int CH_BASE   = 'h100;
   localparam int CH_STRIDE = 'h20;
   localparam int OFF_CFG   = 'h000;
   localparam int OFF_GSTS  = 'h004;
   localparam int OFF_GMSK  = 'h008;
   localparam int OFF_SUM   = 'h010;
   localparam int OFF_SMSK  = 'h014;
   localparam int CH_CTL    = 0;
   localparam int CH_STS    = 2;
   localparam int CH_MSK    = 3;
   localparam logic [31:0] RO_MASK = (32'd1 << HCH_BIT) | (32'd1 << PORT_BIT);
endpackage

// File: rtl/hirq_chan.sv
module hirq_chan
   import hirq_pkg::*;
(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ctl_we,
   input  logic           sts_we,
   input  logic           msk_we,
   input  logic [31:0]    wdata,
   input  logic [STW-1:0] evt,
   output logic           en_o,
   output logic [STW-1:0] sts_o,
   output logic [STW-1:0] msk_o,
   output logic           hit_o
);
   logic           en_q;
   logic [STW-1:0] sts_q, msk_q, clr, halt_set;

   // disabling a running channel marks it halted
   assign halt_set = (ctl_we && en_q && !wdata[0]) ? STW'(1) << HALT_BIT : '0;
   assign clr      = sts_we ? wdata[STW-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         sts_q <= '0;
         msk_q <= '0;
      end else begin
         if (ctl_we) en_q <= wdata[0];
         if (msk_we) msk_q <= wdata[STW-1:0];
         // set sources win over a same-cycle clear
         sts_q <= (sts_q & ~clr) | evt | halt_set;
      end
   end

   assign en_o  = en_q;
   assign sts_o = sts_q;
   assign msk_o = msk_q;
   assign hit_o = |(sts_q & msk_q);
endmodule

// File: rtl/hirq_glob.sv
module hirq_glob
   import hirq_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_we,
   input  logic        sts_we,
   input  logic        msk_we,
   input  logic [31:0] wdata,
   input  logic        hch_i,
   input  logic        port_i,
   input  logic [31:0] sys_evt_i,
   output logic        gie_o,
   output logic [31:0] gsts_o,
   output logic [31:0] gmsk_o,
   output logic        lvl_o,
   output logic        irq_o
);
   logic        gie_q, irq_q;
   logic [31:0] sys_q, gmsk_q, clr;

   assign clr = sts_we ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gie_q  <= 1'b0;
         gmsk_q <= '0;
         sys_q  <= '0;
      end else begin
         if (cfg_we) gie_q <= wdata[0];
         if (msk_we) gmsk_q <= wdata;
         sys_q <= ((sys_q & ~clr) | sys_evt_i) & ~RO_MASK;
      end
   end

   assign gsts_o = sys_q | ({31'd0, hch_i} << HCH_BIT) | ({31'd0, port_i} << PORT_BIT);
   assign gmsk_o = gmsk_q;
   assign gie_o  = gie_q;
   assign lvl_o  = gie_q && |(gsts_o & gmsk_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              irq_q <= 1'b0;
      else if (lvl_o != irq_q) irq_q <= lvl_o;
   end

   assign irq_o = irq_q;
endmodule

// File: rtl/usb_hirq_agg.sv
module usb_hirq_agg
   import hirq_pkg::*;
#(
   parameter int NCH    = 4,
   parameter int ADDR_W = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_we,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [31:0]         reg_wdata,
   output logic [31:0]         reg_rdata,
   input  logic [NCH*STW-1:0]  chan_evt,
   input  logic                port_pend,
   input  logic [31:0]         sys_evt,
   output logic                irq_o
);
   localparam int WIN_W = ADDR_W - 5;

   if (NCH < 1 || NCH > 32) begin : g_bad_nch
      $error("NCH must lie in 1..32");
   end
   if (CH_BASE + NCH * CH_STRIDE > (1 << ADDR_W)) begin : g_bad_aw
      $error("ADDR_W too small for the channel windows");
   end

   logic [NCH-1:0]     ch_sel, ch_en, sum_w;
   logic [NCH*STW-1:0] ch_sts_w, ch_msk_w;
   logic [NCH-1:0]     smsk_q;
   logic [31:0]        gsts_w, gmsk_w;
   logic               gie_w, lvl_w, hch_w;
   logic [2:0]         woff;

   assign woff = reg_addr[4:2];

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      localparam logic [WIN_W-1:0] WIN = WIN_W'((CH_BASE + c * CH_STRIDE) >> 5);
      assign ch_sel[c] = (reg_addr[ADDR_W-1:5] == WIN);

      hirq_chan u_ch (
         .clk    (clk),
         .rst_n  (rst_n),
         .ctl_we (reg_we && ch_sel[c] && woff == 3'(CH_CTL)),
         .sts_we (reg_we && ch_sel[c] && woff == 3'(CH_STS)),
         .msk_we (reg_we && ch_sel[c] && woff == 3'(CH_MSK)),
         .wdata  (reg_wdata),
         .evt    (chan_evt[c*STW +: STW]),
         .en_o   (ch_en[c]),
         .sts_o  (ch_sts_w[c*STW +: STW]),
         .msk_o  (ch_msk_w[c*STW +: STW]),
         .hit_o  (sum_w[c])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) smsk_q <= '0;
      else if (reg_we && reg_addr == ADDR_W'(OFF_SMSK)) smsk_q <= reg_wdata[NCH-1:0];
   end

   assign hch_w = |(sum_w & smsk_q);

   hirq_glob u_glob (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (reg_we && reg_addr == ADDR_W'(OFF_CFG)),
      .sts_we    (reg_we && reg_addr == ADDR_W'(OFF_GSTS)),
      .msk_we    (reg_we && reg_addr == ADDR_W'(OFF_GMSK)),
      .wdata     (reg_wdata),
      .hch_i     (hch_w),
      .port_i    (port_pend),
      .sys_evt_i (sys_evt),
      .gie_o     (gie_w),
      .gsts_o    (gsts_w),
      .gmsk_o    (gmsk_w),
      .lvl_o     (lvl_w),
      .irq_o     (irq_o)
   );

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(OFF_CFG))  reg_rdata = {31'd0, gie_w};
      if (reg_addr == ADDR_W'(OFF_GSTS)) reg_rdata = gsts_w;
      if (reg_addr == ADDR_W'(OFF_GMSK)) reg_rdata = gmsk_w;
      if (reg_addr == ADDR_W'(OFF_SUM))  reg_rdata = 32'(sum_w);
      if (reg_addr == ADDR_W'(OFF_SMSK)) reg_rdata = 32'(smsk_q);
      for (int c = 0; c < NCH; c++) begin
         if (ch_sel[c]) begin
            if (woff == 3'(CH_CTL)) reg_rdata = {31'd0, ch_en[c]};
            if (woff == 3'(CH_STS)) reg_rdata = 32'(ch_sts_w[c*STW +: STW]);
            if (woff == 3'(CH_MSK)) reg_rdata = 32'(ch_msk_w[c*STW +: STW]);
         end
      end
   end
endmodule

// File: rtl/hirq_chk.sv
module hirq_chk
   import hirq_pkg::*;
#(
   parameter int NCH = 4
) (
   input logic           clk,
   input logic           rst_n,
   input logic           irq_o,
   input logic           gie,
   input logic [31:0]    gsts,
   input logic [31:0]    gmsk,
   input logic [NCH-1:0] sum,
   input logic [NCH-1:0] smsk,
   input logic           ctl0_we,
   input logic           wbit0,
   input logic           en0,
   input logic           halt0
);
   logic lvl;
   assign lvl = gie && |(gsts & gmsk);

   assert_irq_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
      lvl |=> irq_o);
   assert_irq_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !lvl |=> !irq_o);
   assert_hch_R5: assert property (@(posedge clk) disable iff (!rst_n)
      gsts[HCH_BIT] == |(sum & smsk));
   assert_glitch_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl == irq_o) |=> $stable(irq_o));
   assert_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl0_we && en0 && !wbit0) |=> (halt0 && !en0));
endmodule

bind usb_hirq_agg hirq_chk #(.NCH(NCH)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .irq_o   (irq_o),
   .gie     (gie_w),
   .gsts    (gsts_w),
   .gmsk    (gmsk_w),
   .sum     (sum_w),
   .smsk    (smsk_q),
   .ctl0_we (reg_we && ch_sel[0] && woff == 3'(hirq_pkg::CH_CTL)),
   .wbit0   (reg_wdata[0]),
   .en0     (ch_en[0]),
   .halt0   (ch_sts_w[hirq_pkg::HALT_BIT])
);

// File: tb/sim_usb_hirq_agg.sv
`timescale 1ns/1ps
module sim_usb_hirq_agg;
   localparam int NCH = 4;
   localparam int AW  = 12;

   logic            clk = 0, rst_n = 0, reg_we = 0, port_pend = 0;
   logic [AW-1:0]   reg_addr = '0;
   logic [31:0]     reg_wdata = '0, sys_evt = '0;
   logic [31:0]     reg_rdata;
   logic [NCH*14-1:0] chan_evt = '0;
   logic            irq_o;
   int              n_run = 0, n_fail = 0;
   bit              done = 0;

   always #2 clk = ~clk;

   usb_hirq_agg #(.NCH(NCH), .ADDR_W(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .chan_evt(chan_evt),
      .port_pend(port_pend), .sys_evt(sys_evt), .irq_o(irq_o));

   // {is_read, addr, data, expect}
   localparam int NV = 11;
   localparam logic [76:0] TBL [NV] = '{
      {1'b0, 12'h10C, 32'hFFFF_FFFF, 32'h0},
      {1'b1, 12'h10C, 32'h0,         32'h0000_3FFF},
      {1'b0, 12'h128, 32'hFFFF_FFFF, 32'h0},
      {1'b1, 12'h128, 32'h0,         32'h0},
      {1'b0, 12'h014, 32'hFFFF_FFFF, 32'h0},
      {1'b1, 12'h014, 32'h0,         32'h0000_000F},
      {1'b0, 12'h008, 32'hFFFF_FFFF, 32'h0},
      {1'b1, 12'h008, 32'h0,         32'hFFFF_FFFF},
      {1'b0, 12'h000, 32'hFFFF_FFFF, 32'h0},
      {1'b1, 12'h000, 32'h0,         32'h1},
      {1'b1, 12'h010, 32'h0,         32'h0}
   };

   task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1;
      @(negedge clk);
      reg_we = 0;
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
      reg_addr = a;
      #0.5;
      chk(reg_rdata, exp, tag);
   endtask

   task automatic cevt(input int ch, input logic [13:0] b);
      @(negedge clk);
      chan_evt[ch*14 +: 14] = b;
      @(negedge clk);
      chan_evt = '0;
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk({31'd0, irq_o}, 32'd0, "R1 irq");
      rd(12'h004, 32'h0, "R1 gsts");
      rd(12'h010, 32'h0, "R1 summary");
      rd(12'h14C, 32'h0, "R1 ch2 mask");
      rd(12'h100, 32'h0, "R1 ch0 enable");
      rst_n = 1;
      @(negedge clk);

      // table: R3 reserved bits, register read-back
      for (int i = 0; i < NV; i++) begin
         if (TBL[i][76]) rd(TBL[i][75:64], TBL[i][31:0], "R3 table");
         else            wr(TBL[i][75:64], TBL[i][63:32]);
      end
      // all masks open except channel masks, enable set

      // R4 masked-off event keeps summary clear
      cevt(2, 14'h20);
      rd(12'h148, 32'h20, "R2 ch2 event");
      rd(12'h010, 32'h0, "R4 masked summary");
      chk({31'd0, irq_o}, 32'd0, "R8 no request");
      wr(12'h14C, 32'h20);
      rd(12'h010, 32'h4, "R4 summary bit 2");
      rd(12'h004, 32'h0200_0000, "R5 global hch");
      chk({31'd0, irq_o}, 32'd0, "R10 latency");
      @(negedge clk);
      chk({31'd0, irq_o}, 32'd1, "R8 request high");

      // R2 W1C on a non-pending bit then the pending one
      wr(12'h148, 32'h10);
      rd(12'h148, 32'h20, "R2 other bit kept");
      chk({31'd0, irq_o}, 32'd1, "R10 steady");
      wr(12'h148, 32'h20);
      rd(12'h148, 32'h0, "R2 cleared");
      rd(12'h004, 32'h0, "R5 hch dropped");
      @(negedge clk);
      chk({31'd0, irq_o}, 32'd0, "R8 request low");

      // R5 summary mask gating
      wr(12'h014, 32'h7);
      cevt(3, 14'h1);
      wr(12'h16C, 32'h1);
      rd(12'h010, 32'h8, "R4 summary bit 3");
      rd(12'h004, 32'h0, "R5 summary mask gates");
      wr(12'h014, 32'hF);
      rd(12'h004, 32'h0200_0000, "R5 ungated");

      // R6 read-only global bits
      port_pend = 1;
      #0.5;
      rd(12'h004, 32'h0300_0000, "R6 port bit");
      wr(12'h004, 32'hFFFF_FFFF);
      rd(12'h004, 32'h0300_0000, "R6 write ignored");
      port_pend = 0;

      // R7 general bits set and cleared
      @(negedge clk);
      sys_evt = 32'h0300_0008;
      @(negedge clk);
      sys_evt = 0;
      rd(12'h004, 32'h0200_0008, "R7 set");
      wr(12'h004, 32'h8);
      rd(12'h004, 32'h0200_0000, "R7 cleared");

      // R8 global enable gate
      wr(12'h000, 32'h0);
      @(negedge clk);
      chk({31'd0, irq_o}, 32'd0, "R8 disabled");
      wr(12'h000, 32'h1);
      @(negedge clk);
      chk({31'd0, irq_o}, 32'd1, "R8 re-enabled");

      // R9 halt on disable
      wr(12'h120, 32'h1);
      rd(12'h120, 32'h1, "R9 enabled");
      wr(12'h120, 32'h0);
      rd(12'h128, 32'h2, "R9 halted");
      rd(12'h120, 32'h0, "R9 enable cleared");
      wr(12'h128, 32'h2);
      wr(12'h120, 32'h0);
      rd(12'h128, 32'h0, "R9 idle disable");

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule